// File: doc/BRIEF.md
# Programmable Pattern Light Chaser

This block drives a row of lamp outputs from a circular register that holds one chase pattern. A load strobe writes an arbitrary pattern into the register. While the run enable is high, an internal rate divider advances the pattern by one position every programmed number of clock cycles. The rotation wraps around, so the pattern returns to where it started after one step per lamp.

The speed value can be changed while the block runs. Each advance raises a one-cycle step strobe, and the strobe appears in the same cycle that the lamps show the new pattern. Dropping the run enable freezes both the pattern and the partly elapsed interval. The reset input is asserted asynchronously and released synchronously on the clock. During reset the pattern and the divider are cleared.

Top module: `lamp_chaser`

## Requirements
- R1: While reset is asserted, and from the first clock edge after it, all lamp outputs and the step strobe are 0.
- R2: A load strobe sampled high copies the pattern input to the lamps on that clock edge and restarts the interval count, so the next advance comes a full interval after the load.
- R3: When load and run are both high on the same edge, the loaded pattern appears unrotated and the step strobe stays 0.
- R4: An advance moves lamp bit i to bit i+1. The highest bit (bit 15) moves into bit 0.
- R5: With run held high and a speed value N of 1 or more, advances come exactly every N clock cycles. The step strobe is high for one cycle, in the cycle the rotated pattern is first visible. The lamps change at no other time, except on a load.
- R6: A speed value of 0 behaves like 1: the pattern advances on every clock cycle.
- R7: While run is low and load is low, the lamps and the elapsed interval count hold and no strobe is raised. After run returns high, the interval continues from where it stopped.
- R8: After 16 advances the lamps show the pattern that was loaded.
- R9: A new speed takes effect at run time. If the elapsed count already reaches the new interval, the next advance happens on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Reset, active low, asserted asynchronously |
| pattern_i | input | 16 | Pattern written into the ring on load |
| load_i | input | 1 | Load strobe |
| speed_i | input | 16 | Clock cycles between advances (0 acts as 1) |
| run_i | input | 1 | Run enable for the divider and the rotation |
| lamp_o | output | 16 | Lamp outputs (ring contents) |
| step_o | output | 1 | One-cycle strobe marking an advance |

## Verification
The bench measures the interval to each strobe, counted from the previous strobe or load. A divider that is off by one, or that is not restarted by a load, therefore shows up as a wrong gap. A pattern with both end bits set, and a single lamp walking across bit 15, expose a rotation in the wrong direction or a lost wrap bit. The bench pauses the run mid-interval, cuts the speed below the count already reached, and raises load and run together. A design that restarts the count after a pause, waits for its counter to roll over after the speed cut, or rotates on a load would each report a wrong gap or pattern.

// File: rtl/chaser_pkg.sv
package chaser_pkg;

  localparam int unsigned LAMP_W_DEF  = 16;
  localparam int unsigned SPEED_W_DEF = 16;

  // What the ring does on the coming edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_LOAD  = 2'd3
  } chase_act_e;

endpackage

// File: rtl/chase_rst_sync.sv
module chase_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/chase_divider.sv
module chase_divider #(
  parameter int unsigned SPEED_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               cnt_en_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               wrap_o
);

  logic [SPEED_W-1:0] cnt_q, cnt_d;
  logic [SPEED_W-1:0] eff_speed;
  logic [SPEED_W-1:0] lim_m1;
  logic               at_limit;

  // A zero speed is treated as one cycle per advance.
  assign eff_speed = (speed_i == '0) ? SPEED_W'(1) : speed_i;
  assign lim_m1    = eff_speed - SPEED_W'(1);
  // Greater-or-equal so a speed cut below the current count wraps at once.
  assign at_limit  = (cnt_q >= lim_m1);
  assign wrap_o    = cnt_en_i & ~clr_i & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_en_i) begin
      cnt_d = at_limit ? '0 : cnt_q + SPEED_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/chase_ring.sv
module chase_ring #(
  parameter int unsigned LAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LAMP_W-1:0] data_i,
  input  logic              shift_i,
  output logic [LAMP_W-1:0] q_o
);

  logic [LAMP_W-1:0] ring_q, ring_d, rotated;

  // Each bit takes its lower neighbour; bit 0 takes the top bit.
  for (genvar i = 0; i < LAMP_W; i++) begin : g_rot
    if (i == 0) begin : g_wrap
      assign rotated[i] = ring_q[LAMP_W-1];
    end else begin : g_link
      assign rotated[i] = ring_q[i-1];
    end
  end

  always_comb begin
    ring_d = ring_q;
    if (load_i) begin
      ring_d = data_i;
    end else if (shift_i) begin
      ring_d = rotated;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign q_o = ring_q;

endmodule

// File: rtl/lamp_chaser.sv
module lamp_chaser
  import chaser_pkg::*;
#(
  parameter int unsigned LAMP_W  = LAMP_W_DEF,
  parameter int unsigned SPEED_W = SPEED_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LAMP_W-1:0]  pattern_i,
  input  logic               load_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic               run_i,
  output logic [LAMP_W-1:0]  lamp_o,
  output logic               step_o
);

  logic       rst_n_q;
  logic       wrap;
  chase_act_e act;
  logic       step_q, step_d;

  chase_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  chase_divider #(.SPEED_W(SPEED_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .clr_i    (load_i),
    .cnt_en_i (run_i),
    .speed_i  (speed_i),
    .wrap_o   (wrap)
  );

  always_comb begin
    if (load_i) begin
      act = ACT_LOAD;
    end else if (!run_i) begin
      act = ACT_HOLD;
    end else if (wrap) begin
      act = ACT_STEP;
    end else begin
      act = ACT_COUNT;
    end
  end

  chase_ring #(.LAMP_W(LAMP_W)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .load_i  (act == ACT_LOAD),
    .data_i  (pattern_i),
    .shift_i (act == ACT_STEP),
    .q_o     (lamp_o)
  );

  // Strobe is registered so it lines up with the rotated lamps.
  assign step_d = (act == ACT_STEP);

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      step_q <= 1'b0;
    end else begin
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/chaser_chk.sv
module chaser_chk #(
  parameter int unsigned LAMP_W  = 16,
  parameter int unsigned SPEED_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_n_q,
  input logic [LAMP_W-1:0]  pattern_i,
  input logic               load_i,
  input logic [SPEED_W-1:0] speed_i,
  input logic               run_i,
  input logic [LAMP_W-1:0]  lamp_o,
  input logic               step_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (lamp_o == '0) && !step_o);

  // R2
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    load_i |=> lamp_o == $past(pattern_i));

  // R3
  load_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    load_i |=> !step_o);

  // R4
  step_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    step_o |-> lamp_o == {$past(lamp_o[LAMP_W-2:0]), $past(lamp_o[LAMP_W-1])});

  // R5
  quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!step_o && !$past(load_i)) |-> $stable(lamp_o));

  // R6
  fast_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (run_i && !load_i && (speed_i <= SPEED_W'(1))) |=> step_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!run_i && !load_i) |=> $stable(lamp_o) && !step_o);

endmodule

bind lamp_chaser chaser_chk #(.LAMP_W(LAMP_W), .SPEED_W(SPEED_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_n_q   (rst_n_q),
  .pattern_i (pattern_i),
  .load_i    (load_i),
  .speed_i   (speed_i),
  .run_i     (run_i),
  .lamp_o    (lamp_o),
  .step_o    (step_o)
);

// File: tb/lamp_chaser_tb.sv
`timescale 1ns/1ps
module lamp_chaser_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pattern;
  logic        load;
  logic [15:0] speed;
  logic        run;
  logic [15:0] lamp;
  logic        step;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 1'b0;

  typedef struct {
    logic [15:0] lamp;
    int unsigned gap;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  lamp_chaser dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pattern_i (pattern),
    .load_i    (load),
    .speed_i   (speed),
    .run_i     (run),
    .lamp_o    (lamp),
    .step_o    (step)
  );

  function automatic logic [15:0] rotl(input logic [15:0] p);
    return {p[14:0], p[15]};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: edge counter and load marker, then strobe scoreboard.
  int unsigned cyc = 0;
  int unsigned last_evt = 0;

  always @(posedge clk) begin
    cyc++;
    if (load) last_evt = cyc;
  end

  always @(negedge clk) begin
    if (rst_n && step) begin
      int unsigned gap;
      exp_t e;
      gap = cyc - last_evt;
      last_evt = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected step", lamp, 16'h0);
      end else begin
        e = exp_q.pop_front();
        chk(lamp == e.lamp, e.req, lamp, e.lamp);
        chk(gap == e.gap, {e.req, " gap"}, 16'(gap), 16'(e.gap));
      end
    end
  end

  task automatic do_load(input logic [15:0] p);
    @(negedge clk);
    pattern = p;
    load    = 1'b1;
    @(negedge clk);
    load    = 1'b0;
  endtask

  task automatic push_steps(input logic [15:0] start, input logic [15:0] spd,
                            input int n, input string req);
    logic [15:0] p = start;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      p = rotl(p);
      e.lamp = p;
      e.gap  = (spd == 16'd0) ? 1 : int'(spd);
      e.req  = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    run = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; run = 1'b0; speed = '0; pattern = '0;
    repeat (5) @(negedge clk);
    chk(lamp == 16'h0 && !step, "R1 in reset", lamp, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lamp == 16'h0 && !step, "R1 after release", lamp, 16'h0);

    // R2 load
    do_load(16'h0006);
    chk(lamp == 16'h0006 && !step, "R2 load", lamp, 16'h0006);

    // R4 direction
    speed = 16'd1; push_steps(16'h0006, 16'd1, 3, "R4 shift up");
    run = 1'b1; drain();
    do_load(16'h8001);
    speed = 16'd1; push_steps(16'h8001, 16'd1, 1, "R4 wrap");
    run = 1'b1; drain();

    // R5 interval
    do_load(16'h0F0F);
    speed = 16'd4; push_steps(16'h0F0F, 16'd4, 5, "R5 interval");
    run = 1'b1; drain();

    // R6 zero speed
    do_load(16'h1000);
    speed = 16'd0; push_steps(16'h1000, 16'd0, 4, "R6 zero speed");
    run = 1'b1; drain();

    // R8 full cycle
    do_load(16'hA5C3);
    speed = 16'd2; push_steps(16'hA5C3, 16'd2, 16, "R8 cycle");
    run = 1'b1; drain();
    @(negedge clk);
    chk(lamp == 16'hA5C3, "R8 back to start", lamp, 16'hA5C3);

    // R7 pause mid-interval
    do_load(16'h0011);
    begin
      exp_t e;
      e.lamp = 16'h0022; e.gap = 8; e.req = "R7 resume";
      exp_q.push_back(e);
    end
    speed = 16'd5; run = 1'b1;
    repeat (2) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    chk(lamp == 16'h0011 && !step, "R7 hold", lamp, 16'h0011);
    run = 1'b1; drain();

    // R3 load wins over rotation
    @(negedge clk);
    pattern = 16'h0F00; load = 1'b1; run = 1'b1; speed = 16'd1;
    @(negedge clk);
    load = 1'b0; run = 1'b0;
    chk(lamp == 16'h0F00 && !step, "R3 priority", lamp, 16'h0F00);

    // R9 speed cut below elapsed count
    do_load(16'h4000);
    begin
      exp_t e;
      e.lamp = 16'h8000; e.gap = 7; e.req = "R9 speed cut";
      exp_q.push_back(e);
    end
    speed = 16'd10; run = 1'b1;
    repeat (6) @(negedge clk);
    speed = 16'd3; drain();

    // R2 reload restarts divider
    do_load(16'h0101);
    speed = 16'd6; run = 1'b1;
    repeat (3) @(negedge clk);
    push_steps(16'h0330, 16'd6, 1, "R2 restart");
    do_load(16'h0330);
    drain();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 leftover", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      chk(1'b0, "watchdog", 16'h0, 16'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule